// File: doc/BRIEF.md
# Ethertype Chain Header Parser

This block walks a packet presented one byte per cycle, starting at the first byte of the Ethernet header. It collects the addresses and type of the Ethernet header, then follows the type value through an optional VLAN header and an optional six-byte source-routing tag. It stops when the chain reaches IPv4 or a type it does not know. The extracted fields and one valid bit per header stay on the outputs until the next packet starts. A one-cycle `done` pulse marks the point where the result can be read.

The parse graph is fixed. After Ethernet, either of two VLAN tag identifiers leads to the VLAN header. After VLAN, a dedicated type value leads to the routing tag. IPv4 may follow any of the three headers. Bytes that arrive after the walk has ended and before the end marker are not examined. IPv4 contents and the payload are not parsed.

Top module: `hdr_walker`

## Requirements
- R1: A packet starts with a byte where `in_valid` and `in_sop` are both high. Bytes 0..5 give `eth_dst`, bytes 6..11 give `eth_src` and bytes 12..13 give `eth_type`, each with the most significant byte first. `eth_ok` rises once byte 13 has been consumed.
- R2: An Ethernet type of 0x8100 or 0x9100 leads to a 4-byte VLAN header. Its first byte holds `vlan_pcp` in bits 7:5, `vlan_cfi` in bit 4 and the top four bits of `vlan_vid` in bits 3:0. The second byte holds the low byte of `vlan_vid`, and the last two bytes hold `vlan_type`. `vlan_ok` is then set.
- R3: A VLAN type of 0xAAAA leads to a 6-byte routing tag, read in the order `tag_up1`, `tag_up2`, `tag_dn1`, `tag_dn2`, then `tag_type`. `tag_ok` is then set.
- R4: A type of 0x0800 after Ethernet, VLAN or routing tag sets `ipv4_ok` and makes `next_proto` 0x0800.
- R5: After the routing tag, any type other than 0x0800, including a VLAN identifier, ends the walk as an unknown protocol.
- R6: Any type that has no edge in the graph sets `unknown_proto` and puts that type on `next_proto`. The valid bits of the headers already read stay set.
- R7: When `in_eop` arrives before the current header is complete, including on the last byte of a header whose type leads to a further header, the block sets `trunc_err`. It then keeps `ipv4_ok` and `unknown_proto` low and leaves `next_proto` at zero.
- R8: `done` is high for exactly the one cycle after the edge that consumed the deciding byte. The deciding byte is the last byte of the chain, or the early end byte for a truncated packet. `done` pulses once per packet.
- R9: Bytes with `in_valid` low are ignored. Valid bytes that arrive after the decision, or outside any packet, without `in_sop` change no output and raise no `done`.
- R10: A start byte restarts parsing from any state and clears all valid bits and result flags.
- R11: After reset, all valid bits, flags, `next_proto` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_byte | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| eth_dst | output | 48 | Destination address |
| eth_src | output | 48 | Source address |
| eth_type | output | 16 | Ethernet type |
| vlan_pcp | output | 3 | VLAN priority |
| vlan_cfi | output | 1 | VLAN format indicator |
| vlan_vid | output | 12 | VLAN identifier |
| vlan_type | output | 16 | Type after VLAN |
| tag_up1 | output | 8 | Routing tag, first upward hop |
| tag_up2 | output | 8 | Routing tag, second upward hop |
| tag_dn1 | output | 8 | Routing tag, first downward hop |
| tag_dn2 | output | 8 | Routing tag, second downward hop |
| tag_type | output | 16 | Type after routing tag |
| eth_ok | output | 1 | Ethernet header extracted |
| vlan_ok | output | 1 | VLAN header extracted |
| tag_ok | output | 1 | Routing tag extracted |
| ipv4_ok | output | 1 | Chain reached IPv4 |
| unknown_proto | output | 1 | Chain ended on an unknown type |
| trunc_err | output | 1 | Packet ended inside a header |
| next_proto | output | 16 | Type that ended the chain |
| done | output | 1 | One-cycle result pulse |

## Verification
Two events can fall on the same byte. In the first, the end marker arrives on the last byte of a header at the moment the type decision is made. In the second, a start byte and an end byte coincide, so the restart and the truncation meet in one cycle. The bench builds packets whose length stops exactly at a header boundary, or one byte short of it, and sends one-byte packets. For these cases it expects truncation only when the type asks for a further header, and IPv4 or unknown otherwise. A reference walk over the same byte array in the bench gives the expected flags, fields and the index of the byte that must produce `done`.

// File: rtl/hdr_walker.sv
module hdr_walker #(
  parameter logic [15:0] TPID_A    = 16'h8100,
  parameter logic [15:0] TPID_B    = 16'h9100,
  parameter logic [15:0] TAG_TYPE  = 16'hAAAA,
  parameter logic [15:0] IPV4_TYPE = 16'h0800,
  parameter int ETH_LEN  = 14,
  parameter int VLAN_LEN = 4,
  parameter int TAG_LEN  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic [47:0] eth_dst,
  output logic [47:0] eth_src,
  output logic [15:0] eth_type,
  output logic [2:0]  vlan_pcp,
  output logic        vlan_cfi,
  output logic [11:0] vlan_vid,
  output logic [15:0] vlan_type,
  output logic [7:0]  tag_up1,
  output logic [7:0]  tag_up2,
  output logic [7:0]  tag_dn1,
  output logic [7:0]  tag_dn2,
  output logic [15:0] tag_type,
  output logic        eth_ok,
  output logic        vlan_ok,
  output logic        tag_ok,
  output logic        ipv4_ok,
  output logic        unknown_proto,
  output logic        trunc_err,
  output logic [15:0] next_proto,
  output logic        done
);
  localparam int SHW = ETH_LEN * 8;
  localparam int CW  = $clog2(ETH_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_ETH, S_VLAN, S_TAG, S_SKIP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [SHW-1:0] sh;
  logic [SHW-1:0] sh_next;
  logic [15:0]    cur_type;
  logic           body_byte;
  logic           hdr_last;
  logic           go_vlan;
  logic           go_tag;
  logic           more;

  assign sh_next   = {sh[SHW-9:0], in_byte};
  assign cur_type  = sh_next[15:0];
  assign body_byte = in_valid && !in_sop;
  assign hdr_last  = body_byte &&
                     ((st == S_ETH  && cnt == CW'(ETH_LEN - 1))  ||
                      (st == S_VLAN && cnt == CW'(VLAN_LEN - 1)) ||
                      (st == S_TAG  && cnt == CW'(TAG_LEN - 1)));
  assign go_vlan   = (st == S_ETH)  && (cur_type == TPID_A || cur_type == TPID_B);
  assign go_tag    = (st == S_VLAN) && (cur_type == TAG_TYPE);
  assign more      = go_vlan || go_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      eth_dst <= '0;
      eth_src <= '0;
      eth_type <= '0;
      vlan_pcp <= '0;
      vlan_cfi <= 1'b0;
      vlan_vid <= '0;
      vlan_type <= '0;
      tag_up1 <= '0;
      tag_up2 <= '0;
      tag_dn1 <= '0;
      tag_dn2 <= '0;
      tag_type <= '0;
      eth_ok <= 1'b0;
      vlan_ok <= 1'b0;
      tag_ok <= 1'b0;
      ipv4_ok <= 1'b0;
      unknown_proto <= 1'b0;
      trunc_err <= 1'b0;
      next_proto <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid && in_sop) begin
        eth_ok <= 1'b0;
        vlan_ok <= 1'b0;
        tag_ok <= 1'b0;
        ipv4_ok <= 1'b0;
        unknown_proto <= 1'b0;
        trunc_err <= 1'b0;
        next_proto <= '0;
        sh <= sh_next;
        cnt <= CW'(1);
        if (in_eop) begin
          trunc_err <= 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end else begin
          st <= S_ETH;
        end
      end else if (hdr_last) begin
        sh <= sh_next;
        cnt <= '0;
        case (st)
          S_ETH: begin
            eth_dst <= sh_next[111:64];
            eth_src <= sh_next[63:16];
            eth_type <= cur_type;
            eth_ok <= 1'b1;
          end
          S_VLAN: begin
            vlan_pcp <= sh_next[31:29];
            vlan_cfi <= sh_next[28];
            vlan_vid <= sh_next[27:16];
            vlan_type <= cur_type;
            vlan_ok <= 1'b1;
          end
          default: begin
            tag_up1 <= sh_next[47:40];
            tag_up2 <= sh_next[39:32];
            tag_dn1 <= sh_next[31:24];
            tag_dn2 <= sh_next[23:16];
            tag_type <= cur_type;
            tag_ok <= 1'b1;
          end
        endcase
        if (more && in_eop) begin
          trunc_err <= 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end else if (more) begin
          st <= go_vlan ? S_VLAN : S_TAG;
        end else begin
          done <= 1'b1;
          next_proto <= cur_type;
          ipv4_ok <= (cur_type == IPV4_TYPE);
          unknown_proto <= (cur_type != IPV4_TYPE);
          st <= in_eop ? S_IDLE : S_SKIP;
        end
      end else if (body_byte) begin
        case (st)
          S_ETH, S_VLAN, S_TAG: begin
            sh <= sh_next;
            cnt <= cnt + CW'(1);
            if (in_eop) begin
              trunc_err <= 1'b1;
              done <= 1'b1;
              st <= S_IDLE;
            end
          end
          S_SKIP: if (in_eop) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdr_walker_chk.sv
module hdr_walker_chk #(
  parameter logic [15:0] IPV4_TYPE = 16'h0800
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sop,
  input logic        in_eop,
  input logic        eth_ok,
  input logic        vlan_ok,
  input logic        tag_ok,
  input logic        ipv4_ok,
  input logic        unknown_proto,
  input logic        trunc_err,
  input logic [15:0] next_proto,
  input logic        done
);
  p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ipv4_ok, unknown_proto, trunc_err}));

  p_done_has_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ipv4_ok || unknown_proto || trunc_err));

  p_ipv4_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ipv4_ok |-> (eth_ok && next_proto == IPV4_TYPE));

  p_tag_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_ok |-> (vlan_ok && eth_ok));

  p_unknown_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_proto |-> (eth_ok && next_proto != IPV4_TYPE));

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !in_eop) |=> (!eth_ok && !vlan_ok && !tag_ok && !ipv4_ok && !unknown_proto && !trunc_err && !done));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
endmodule

bind hdr_walker hdr_walker_chk #(.IPV4_TYPE(IPV4_TYPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
  .eth_ok(eth_ok), .vlan_ok(vlan_ok), .tag_ok(tag_ok), .ipv4_ok(ipv4_ok),
  .unknown_proto(unknown_proto), .trunc_err(trunc_err), .next_proto(next_proto),
  .done(done));

// File: tb/hdr_walker_bench.sv
module hdr_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_sop = 1'b0;
  logic in_eop = 1'b0;
  logic [47:0] eth_dst, eth_src;
  logic [15:0] eth_type, vlan_type, tag_type, next_proto;
  logic [2:0] vlan_pcp;
  logic vlan_cfi;
  logic [11:0] vlan_vid;
  logic [7:0] tag_up1, tag_up2, tag_dn1, tag_dn2;
  logic eth_ok, vlan_ok, tag_ok, ipv4_ok, unknown_proto, trunc_err, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_walker u_hdr_walker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_sop(in_sop), .in_eop(in_eop),
    .eth_dst(eth_dst), .eth_src(eth_src), .eth_type(eth_type),
    .vlan_pcp(vlan_pcp), .vlan_cfi(vlan_cfi), .vlan_vid(vlan_vid), .vlan_type(vlan_type),
    .tag_up1(tag_up1), .tag_up2(tag_up2), .tag_dn1(tag_dn1), .tag_dn2(tag_dn2),
    .tag_type(tag_type), .eth_ok(eth_ok), .vlan_ok(vlan_ok), .tag_ok(tag_ok),
    .ipv4_ok(ipv4_ok), .unknown_proto(unknown_proto), .trunc_err(trunc_err),
    .next_proto(next_proto), .done(done));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] pkt [64];
  int plen;

  bit e_eth, e_vlan, e_tag, e_ipv4, e_unk, e_trunc;
  logic [15:0] e_next;
  int e_done_idx;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w16(input int i);
    return {pkt[i], pkt[i+1]};
  endfunction

  task automatic model();
    logic [15:0] t;
    e_eth = 0; e_vlan = 0; e_tag = 0; e_ipv4 = 0; e_unk = 0; e_trunc = 0;
    e_next = '0; e_done_idx = plen - 1;
    if (plen < 14) begin e_trunc = 1; return; end
    e_eth = 1; t = w16(12);
    if (t == 16'h8100 || t == 16'h9100) begin
      if (plen < 18) begin e_trunc = 1; return; end
      e_vlan = 1; t = w16(16);
      if (t == 16'hAAAA) begin
        if (plen < 24) begin e_trunc = 1; return; end
        e_tag = 1; t = w16(22); e_done_idx = 23;
      end else e_done_idx = 17;
    end else e_done_idx = 13;
    e_next = t;
    if (t == 16'h0800) e_ipv4 = 1; else e_unk = 1;
  endtask

  task automatic cyc(input bit v, input logic [7:0] b, input bit s, input bit e, input bit exp_done, inout bit bad);
    in_valid = v; in_byte = b; in_sop = s; in_eop = e;
    @(negedge clk);
    if (done !== exp_done) bad = 1;
  endtask

  task automatic run_pkt(input int gap_pct, input string tag);
    bit bad = 0;
    model();
    for (int i = 0; i < plen; i++) begin
      if ($urandom_range(99) < gap_pct) cyc(0, 8'($urandom), 0, 0, 0, bad);
      cyc(1, pkt[i], i == 0, i == plen - 1, i == e_done_idx, bad);
    end
    for (int j = 0; j < 3; j++) cyc(1, 8'($urandom), 0, j == 2, 0, bad);
    cyc(0, 8'h00, 0, 0, 0, bad);
    chk(!bad, {"R8 done timing ", tag}, 64'(done), 64'(0));
    chk({eth_ok, vlan_ok, tag_ok} == {e_eth, e_vlan, e_tag}, {"R1/R2/R3 valid bits ", tag},
        64'({eth_ok, vlan_ok, tag_ok}), 64'({e_eth, e_vlan, e_tag}));
    chk({ipv4_ok, unknown_proto, trunc_err} == {e_ipv4, e_unk, e_trunc}, {"R4 R5 R6 R7 flags ", tag},
        64'({ipv4_ok, unknown_proto, trunc_err}), 64'({e_ipv4, e_unk, e_trunc}));
    chk(next_proto == e_next, {"R6 next_proto ", tag}, 64'(next_proto), 64'(e_next));
    if (e_eth) begin
      chk(eth_dst == {pkt[0], pkt[1], pkt[2], pkt[3], pkt[4], pkt[5]} &&
          eth_src == {pkt[6], pkt[7], pkt[8], pkt[9], pkt[10], pkt[11]},
          {"R1 addresses ", tag}, 64'(eth_dst), 64'({pkt[0], pkt[1], pkt[2], pkt[3], pkt[4], pkt[5]}));
      chk(eth_type == w16(12), {"R1 eth_type ", tag}, 64'(eth_type), 64'(w16(12)));
    end
    if (e_vlan) begin
      chk({vlan_pcp, vlan_cfi, vlan_vid} == w16(14) && vlan_type == w16(16), {"R2 vlan fields ", tag},
          64'({vlan_pcp, vlan_cfi, vlan_vid, vlan_type}), 64'({w16(14), w16(16)}));
    end
    if (e_tag) begin
      chk({tag_up1, tag_up2, tag_dn1, tag_dn2, tag_type} == {pkt[18], pkt[19], pkt[20], pkt[21], w16(22)},
          {"R3 tag fields ", tag}, 64'({tag_up1, tag_up2, tag_dn1, tag_dn2, tag_type}),
          64'({pkt[18], pkt[19], pkt[20], pkt[21], w16(22)}));
    end
  endtask

  task automatic build(input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2, input int len);
    for (int i = 0; i < 64; i++) pkt[i] = 8'($urandom);
    pkt[12] = t0[15:8]; pkt[13] = t0[7:0];
    pkt[16] = t1[15:8]; pkt[17] = t1[7:0];
    pkt[22] = t2[15:8]; pkt[23] = t2[7:0];
    plen = len;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(5))
      0: return 16'h8100;
      1: return 16'h9100;
      2: return 16'hAAAA;
      3, 4: return 16'h0800;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit bad;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({eth_ok, vlan_ok, tag_ok, ipv4_ok, unknown_proto, trunc_err, done} == 7'b0 && next_proto == 16'h0,
        "R11 reset state", 64'({eth_ok, vlan_ok, tag_ok, ipv4_ok, unknown_proto, trunc_err, done}), 64'(0));

    build(16'h0800, 16'h0, 16'h0, 14); run_pkt(0, "eth->ipv4 exact R4");
    build(16'h9100, 16'h0800, 16'h0, 22); run_pkt(0, "9100 vlan->ipv4 R2");
    build(16'h8100, 16'hAAAA, 16'h0800, 30); run_pkt(30, "vlan->tag->ipv4 R3");
    build(16'h8100, 16'hAAAA, 16'h8100, 24); run_pkt(0, "tag->8100 unknown R5");
    build(16'h1234, 16'h0, 16'h0, 20); run_pkt(0, "eth unknown R6");
    build(16'h8100, 16'h0, 16'h0, 6); run_pkt(0, "trunc in eth R7");
    build(16'h8100, 16'h0, 16'h0, 14); run_pkt(0, "eop on boundary wants vlan R7");
    build(16'h8100, 16'hAAAA, 16'h0, 18); run_pkt(0, "eop on boundary wants tag R7");
    build(16'h0800, 16'h0, 16'h0, 1); run_pkt(0, "sop with eop R7");

    bad = 0;
    for (int i = 0; i < 8; i++) cyc(1, 8'($urandom), i == 0, 0, 0, bad);
    chk(!bad && !eth_ok && !trunc_err, "R10 partial packet quiet", 64'({eth_ok, trunc_err}), 64'(0));
    build(16'h0800, 16'h0, 16'h0, 16); run_pkt(0, "restart mid packet R10");
    cyc(1, 8'h55, 1, 0, 0, bad);
    chk({eth_ok, ipv4_ok, unknown_proto, trunc_err} == 4'b0, "R10 start byte clears flags",
        64'({eth_ok, ipv4_ok, unknown_proto, trunc_err}), 64'(0));
    build(16'h8100, 16'h0800, 16'h0, 20); run_pkt(0, "after restart R9");

    for (int n = 0; n < 60; n++) begin
      int full;
      build(pick(), pick(), pick(), 0);
      full = 14;
      if (w16(12) == 16'h8100 || w16(12) == 16'h9100) full = (w16(16) == 16'hAAAA) ? 24 : 18;
      if ($urandom_range(3) == 0) plen = 1 + $urandom_range(full - 1);
      else plen = full + $urandom_range(6);
      run_pkt(25, "random R9");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule